// File: doc/BRIEF.md
# Rename Undo Log

This block keeps an ordered record of register renames made by an out-of-order rename stage. Each destination that is renamed adds one record at the young end. A record holds the instruction's sequence number, the architectural register, the newly assigned physical register and the physical register that the architectural register mapped to before the rename. An instruction that writes no register adds a single marker record that carries only its sequence number. Marker records keep the ordering complete, but they cause no map or free-list traffic.

The block has two recovery paths that walk the record from opposite ends, one record per cycle. A squash request names the youngest sequence number that survives. Records younger than it are popped from the young end. For each popped record, the block writes the old mapping back into the external map table and returns the new physical register to the external free list. A commit request names the youngest retired sequence number. Records at the old end up to and including that number are popped, and each one returns its previous physical register to the free list. While a walk is in progress the block raises `busy`, and the rename stage must hold new inserts. `full` tells the stage that no slot remains.

Top module: `rename_undo_log`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `busy` is 0, and `map_wr_valid` and `free_valid` are 0.
- R2: An insert is accepted when all of the following hold: `ins_valid` is 1, `busy` is 0, `full` is 0, and neither `sq_valid` nor `cm_valid` is raised in the same cycle. The accepted record goes to the young end. `ins_has_dst`=0 makes a marker record. An instruction with several destinations is inserted as consecutive records with the same sequence number.
- R3: `full` is 1 exactly when DEPTH records are held. An insert presented while `full` is 1 is dropped.
- R4: A squash request with sequence S pops records from the young end, one per cycle, while the youngest record's sequence is greater than S. Sequence numbers are compared as unsigned values that do not wrap. Each popped non-marker record raises `map_wr_valid` with (arch, previous phys) and `free_valid` with the new phys in the same cycle, youngest record first.
- R5: A popped marker record, whether popped by a squash or by a commit, takes one walk cycle but raises neither `map_wr_valid` nor `free_valid`.
- R6: A squash request while the log is empty has no effect: `busy` stays 0 and no pulses appear.
- R7: A commit request with sequence N pops records from the old end, one per cycle, while the oldest record's sequence is less than or equal to N. Each popped non-marker record raises `free_valid` with its previous phys, oldest record first. `map_wr_valid` stays 0.
- R8: A commit request is ignored when the log is empty or when the oldest record's sequence is greater than N.
- R9: A commit request that arrives during a squash walk is ignored.
- R10: `busy` is 1 from the cycle after a walk is accepted until the walk ends. Inserts presented while `busy` is 1 are dropped.
- R11: A squash request that arrives during a commit walk is carried out after that walk ends. A squash request that arrives during a squash walk with an older sequence lowers the walk's limit.
- R12: When several requests arrive in the same cycle, squash wins over commit, and commit wins over insert. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert one record |
| ins_seq | input | SEQ_W | Sequence number of the instruction being inserted |
| ins_has_dst | input | 1 | 1 for a rename record, 0 for a marker record |
| ins_arch | input | ARCH_W | Architectural destination register |
| ins_new | input | PHYS_W | Newly assigned physical register |
| ins_prev | input | PHYS_W | Physical register the destination mapped to before this rename |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest sequence number that survives the squash |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Youngest committed sequence number |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | No free slot |
| empty | output | 1 | No records held |
| map_wr_valid | output | 1 | Restore-write strobe to the map table |
| map_wr_arch | output | ARCH_W | Map entry to restore |
| map_wr_phys | output | PHYS_W | Physical register written back to the map entry |
| free_valid | output | 1 | Free-list return strobe |
| free_phys | output | PHYS_W | Physical register returned to the free list |

## Verification
The bench builds the log with DEPTH=8 and keeps the default field widths. The small depth lets a handful of inserts reach `full`, so the dropped-insert case can be seen through the commit frees that follow. The directed scenarios use sequence numbers that are shared by several records and mixed with marker records. They also raise requests that collide in the same cycle and requests that arrive in the middle of a walk, so the ordering and priority rules can be seen in the pulse streams at the ports.

// File: rtl/rul_pkg.sv
package rul_pkg;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_SQUASH = 2'd1,
        W_COMMIT = 2'd2
    } walk_e;

endpackage

// File: rtl/rul_ring.sv
module rul_ring #(
    parameter int DEPTH = 32,
    parameter int EW    = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_data,
    input  logic          pop_old,
    input  logic          pop_young,
    output logic [EW-1:0] old_data,
    output logic [EW-1:0] young_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t st_q, st_d;
    logic [EW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] inc_p(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] dec_p(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    assign old_data   = mem_q[st_q.head];
    assign young_data = mem_q[dec_p(st_q.tail)];
    assign empty      = (st_q.cnt == '0);
    assign full       = (st_q.cnt == CW'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tail = inc_p(st_q.tail);
            st_d.cnt  = st_q.cnt + CW'(1);
        end else if (pop_old) begin
            st_d.head = inc_p(st_q.head);
            st_d.cnt  = st_q.cnt - CW'(1);
        end else if (pop_young) begin
            st_d.tail = dec_p(st_q.tail);
            st_d.cnt  = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.tail] <= wr_data;
    end

    // R3: the walker never writes into a full ring
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R4: pops only happen on a non-empty ring
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old || pop_young) |-> !empty);
    // R10: one ring operation per cycle
    p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, pop_old, pop_young}) <= 1);
    // R3: occupancy tracks the operation of the previous cycle
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> !empty);

endmodule

// File: rtl/rul_walk.sv
module rul_walk
    import rul_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 7,
    parameter int EW     = 1 + SEQ_W + ARCH_W + 2 * PHYS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sq_valid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              cm_valid,
    input  logic [SEQ_W-1:0]  cm_seq,
    input  logic              ins_valid,
    input  logic              empty,
    input  logic              full,
    input  logic [EW-1:0]     old_data,
    input  logic [EW-1:0]     young_data,
    output logic              wr_en,
    output logic              pop_old,
    output logic              pop_young,
    output logic              busy,
    output logic              map_wr_valid,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PHYS_W-1:0] map_wr_phys,
    output logic              free_valid,
    output logic [PHYS_W-1:0] free_phys
);
    typedef struct packed {
        logic              mark;
        logic [SEQ_W-1:0]  seq;
        logic [ARCH_W-1:0] arch;
        logic [PHYS_W-1:0] newp;
        logic [PHYS_W-1:0] prevp;
    } rec_t;

    typedef struct packed {
        walk_e             st;
        logic [SEQ_W-1:0]  lim;
        logic              pend;
        logic [SEQ_W-1:0]  pend_seq;
        logic              rv;
        logic [ARCH_W-1:0] ra;
        logic [PHYS_W-1:0] rp;
        logic              fv;
        logic [PHYS_W-1:0] fp;
    } walk_t;

    walk_t st_q, st_d;
    rec_t  old_r, young_r;
    logic [SEQ_W-1:0] sq_lim, cm_lim, pend_seq_now;
    logic             pend_now;

    assign old_r   = rec_t'(old_data);
    assign young_r = rec_t'(young_data);

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        st_d.fv   = 1'b0;
        wr_en     = 1'b0;
        pop_old   = 1'b0;
        pop_young = 1'b0;
        sq_lim    = (sq_valid && sq_seq < st_q.lim) ? sq_seq : st_q.lim;
        cm_lim    = (cm_valid && cm_seq > st_q.lim) ? cm_seq : st_q.lim;
        pend_now  = st_q.pend || sq_valid;
        pend_seq_now = st_q.pend_seq;
        if (sq_valid && (!st_q.pend || sq_seq < st_q.pend_seq))
            pend_seq_now = sq_seq;

        unique case (st_q.st)
            W_IDLE: begin
                if (sq_valid) begin
                    if (!empty) begin
                        st_d.st  = W_SQUASH;
                        st_d.lim = sq_seq;
                    end
                end else if (cm_valid) begin
                    if (!empty && old_r.seq <= cm_seq) begin
                        st_d.st  = W_COMMIT;
                        st_d.lim = cm_seq;
                    end
                end else if (ins_valid && !full) begin
                    wr_en = 1'b1;
                end
            end
            W_SQUASH: begin
                st_d.lim = sq_lim;
                if (!empty && young_r.seq > sq_lim) begin
                    pop_young = 1'b1;
                    if (!young_r.mark) begin
                        st_d.rv = 1'b1;
                        st_d.ra = young_r.arch;
                        st_d.rp = young_r.prevp;
                        st_d.fv = 1'b1;
                        st_d.fp = young_r.newp;
                    end
                end else begin
                    st_d.st = W_IDLE;
                end
            end
            W_COMMIT: begin
                st_d.lim      = cm_lim;
                st_d.pend     = pend_now;
                st_d.pend_seq = pend_seq_now;
                if (!empty && old_r.seq <= cm_lim) begin
                    pop_old = 1'b1;
                    if (!old_r.mark) begin
                        st_d.fv = 1'b1;
                        st_d.fp = old_r.prevp;
                    end
                end else if (pend_now) begin
                    st_d.st   = W_SQUASH;
                    st_d.lim  = pend_seq_now;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.st = W_IDLE;
                end
            end
            default: st_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= W_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = (st_q.st != W_IDLE);
    assign map_wr_valid = st_q.rv;
    assign map_wr_arch  = st_q.ra;
    assign map_wr_phys  = st_q.rp;
    assign free_valid   = st_q.fv;
    assign free_phys    = st_q.fp;

    // R4: every map restore comes with a free of the same record
    p_restore_pairs_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> free_valid);
    // R7: restores only follow a squash-walk cycle
    p_restore_from_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> $past(st_q.st == W_SQUASH));
    // R10: pulses appear only while a walk is in progress
    p_pulse_in_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> busy);
    // R10: no insert while busy
    p_no_insert_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);
    // R9: a squash walk never pops from the old end
    p_squash_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == W_SQUASH) |-> !pop_old);
    // R6: a squash on an empty log leaves the walker idle
    p_empty_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sq_valid && empty) |=> !busy);

endmodule

// File: rtl/rename_undo_log.sv
module rename_undo_log #(
    parameter int DEPTH  = 32,
    parameter int SEQ_W  = 8,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic              ins_has_dst,
    input  logic [ARCH_W-1:0] ins_arch,
    input  logic [PHYS_W-1:0] ins_new,
    input  logic [PHYS_W-1:0] ins_prev,
    input  logic              sq_valid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              cm_valid,
    input  logic [SEQ_W-1:0]  cm_seq,
    output logic              busy,
    output logic              full,
    output logic              empty,
    output logic              map_wr_valid,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PHYS_W-1:0] map_wr_phys,
    output logic              free_valid,
    output logic [PHYS_W-1:0] free_phys
);
    localparam int EW = 1 + SEQ_W + ARCH_W + 2 * PHYS_W;

    logic          wr_en, pop_old, pop_young;
    logic [EW-1:0] wr_data, old_data, young_data;

    assign wr_data = {~ins_has_dst, ins_seq, ins_arch, ins_new, ins_prev};

    rul_ring #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pop_old    (pop_old),
        .pop_young  (pop_young),
        .old_data   (old_data),
        .young_data (young_data),
        .empty      (empty),
        .full       (full)
    );

    rul_walk #(
        .SEQ_W  (SEQ_W),
        .ARCH_W (ARCH_W),
        .PHYS_W (PHYS_W),
        .EW     (EW)
    ) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .sq_valid     (sq_valid),
        .sq_seq       (sq_seq),
        .cm_valid     (cm_valid),
        .cm_seq       (cm_seq),
        .ins_valid    (ins_valid),
        .empty        (empty),
        .full         (full),
        .old_data     (old_data),
        .young_data   (young_data),
        .wr_en        (wr_en),
        .pop_old      (pop_old),
        .pop_young    (pop_young),
        .busy         (busy),
        .map_wr_valid (map_wr_valid),
        .map_wr_arch  (map_wr_arch),
        .map_wr_phys  (map_wr_phys),
        .free_valid   (free_valid),
        .free_phys    (free_phys)
    );

    // R2: an insert with no competing request on an idle, non-full log lands
    p_insert_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !busy && !full && !sq_valid && !cm_valid) |=> !empty);
    // R12: a squash on a non-empty idle log wins over everything else
    p_squash_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sq_valid && !empty) |=> busy);

endmodule

// File: tb/rename_undo_log_test.sv
module rename_undo_log_test;
    localparam int DEPTH = 8;
    localparam int SEQ_W = 8;
    localparam int ARCH_W = 5;
    localparam int PHYS_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 0, ins_has_dst = 0, sq_valid = 0, cm_valid = 0;
    logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0, cm_seq = '0;
    logic [ARCH_W-1:0] ins_arch = '0;
    logic [PHYS_W-1:0] ins_new = '0, ins_prev = '0;
    logic busy, full, empty, map_wr_valid, free_valid;
    logic [ARCH_W-1:0] map_wr_arch;
    logic [PHYS_W-1:0] map_wr_phys, free_phys;

    int total = 0;
    int bad = 0;
    int fl[$];
    int ra[$];
    int rp[$];

    always #10 clk = ~clk;

    rename_undo_log #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_has_dst(ins_has_dst),
        .ins_arch(ins_arch), .ins_new(ins_new), .ins_prev(ins_prev),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .cm_valid(cm_valid), .cm_seq(cm_seq),
        .busy(busy), .full(full), .empty(empty),
        .map_wr_valid(map_wr_valid), .map_wr_arch(map_wr_arch), .map_wr_phys(map_wr_phys),
        .free_valid(free_valid), .free_phys(free_phys)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (free_valid) fl.push_back(int'(free_phys));
            if (map_wr_valid) begin
                ra.push_back(int'(map_wr_arch));
                rp.push_back(int'(map_wr_phys));
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic clear_logs();
        fl.delete();
        ra.delete();
        rp.delete();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    task automatic push(input int seq, input bit has, input int arch, input int nw, input int pv);
        ins_valid = 1; ins_seq = SEQ_W'(seq); ins_has_dst = has;
        ins_arch = ARCH_W'(arch); ins_new = PHYS_W'(nw); ins_prev = PHYS_W'(pv);
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic squash(input int seq);
        sq_valid = 1; sq_seq = SEQ_W'(seq);
        @(negedge clk);
        sq_valid = 0;
        wait_idle();
    endtask

    task automatic commit(input int seq);
        cm_valid = 1; cm_seq = SEQ_W'(seq);
        @(negedge clk);
        cm_valid = 0;
        wait_idle();
    endtask

    task automatic t_reset();
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 map_wr_valid", int'(map_wr_valid), 0);
        check("R1 free_valid", int'(free_valid), 0);
    endtask

    task automatic t_commit_basic();
        clear_logs();
        push(1, 1, 3, 10, 3);
        push(2, 0, 0, 0, 0);
        push(3, 1, 4, 11, 4);
        push(3, 1, 5, 12, 5);
        check("R2 not empty", int'(empty), 0);
        commit(1);
        check("R7 one free", fl.size(), 1);
        if (fl.size() > 0) check("R7 free prev", fl[0], 3);
        clear_logs();
        commit(2);
        check("R5 marker no free", fl.size(), 0);
        check("R5 marker popped", int'(empty), 0);
        commit(3);
        check("R7 two frees", fl.size(), 2);
        if (fl.size() > 1) begin
            check("R7 oldest first", fl[0], 4);
            check("R7 second", fl[1], 5);
        end
        check("R7 no restore", ra.size(), 0);
        check("R7 empty after", int'(empty), 1);
    endtask

    task automatic t_squash_basic();
        clear_logs();
        push(10, 1, 1, 20, 1);
        push(11, 0, 0, 0, 0);
        push(12, 1, 2, 21, 2);
        push(13, 1, 3, 22, 3);
        squash(10);
        check("R4 restore count", ra.size(), 2);
        check("R4 free count", fl.size(), 2);
        if (ra.size() > 1 && fl.size() > 1) begin
            check("R4 youngest arch", ra[0], 3);
            check("R4 youngest prev", rp[0], 3);
            check("R4 youngest new", fl[0], 22);
            check("R4 next arch", ra[1], 2);
            check("R4 next new", fl[1], 21);
        end
        check("R4 survivor kept", int'(empty), 0);
        clear_logs();
        commit(10);
        check("R4 survivor free", fl.size(), 1);
        if (fl.size() > 0) check("R4 survivor prev", fl[0], 1);
        check("R4 empty", int'(empty), 1);
    endtask

    task automatic t_squash_empty();
        clear_logs();
        sq_valid = 1; sq_seq = 5;
        @(negedge clk);
        sq_valid = 0;
        check("R6 busy stays low", int'(busy), 0);
        @(negedge clk);
        check("R6 no pulses", fl.size() + ra.size(), 0);
    endtask

    task automatic t_commit_ignored();
        clear_logs();
        push(20, 1, 6, 30, 6);
        cm_valid = 1; cm_seq = 15;
        @(negedge clk);
        cm_valid = 0;
        check("R8 too old busy", int'(busy), 0);
        wait_idle();
        check("R8 too old no free", fl.size(), 0);
        commit(20);
        check("R8 then real commit", fl.size(), 1);
        clear_logs();
        cm_valid = 1; cm_seq = 25;
        @(negedge clk);
        cm_valid = 0;
        check("R8 empty busy", int'(busy), 0);
        check("R8 empty no free", fl.size(), 0);
    endtask

    task automatic t_full();
        clear_logs();
        for (int i = 0; i < DEPTH; i++) push(30 + i, 1, i, 50 + i, 40 + i);
        check("R3 full", int'(full), 1);
        push(38, 1, 9, 60, 63);
        commit(38);
        check("R3 extra dropped", fl.size(), DEPTH);
        for (int i = 0; i < fl.size(); i++) check("R3 free order", fl[i], 40 + i);
        check("R3 not full", int'(full), 0);
    endtask

    task automatic t_busy_blocks();
        clear_logs();
        for (int i = 0; i < 4; i++) push(50 + i, 1, i + 1, 10 + i, 20 + i);
        sq_valid = 1; sq_seq = 50;
        @(negedge clk);
        sq_valid = 0;
        check("R10 busy high", int'(busy), 1);
        ins_valid = 1; ins_seq = 60; ins_has_dst = 1; ins_prev = 99;
        cm_valid = 1; cm_seq = 50;
        @(negedge clk);
        ins_valid = 0; cm_valid = 0;
        wait_idle();
        check("R9 only squash restores", ra.size(), 3);
        check("R9 only squash frees", fl.size(), 3);
        clear_logs();
        commit(100);
        check("R10 insert dropped", fl.size(), 1);
        if (fl.size() > 0) check("R9 commit dropped", fl[0], 20);
    endtask

    task automatic t_priority();
        clear_logs();
        push(70, 1, 7, 33, 34);
        push(71, 1, 8, 35, 36);
        sq_valid = 1; sq_seq = 70;
        cm_valid = 1; cm_seq = 71;
        ins_valid = 1; ins_seq = 72; ins_has_dst = 1; ins_prev = 90;
        @(negedge clk);
        sq_valid = 0; cm_valid = 0; ins_valid = 0;
        wait_idle();
        check("R12 squash restores", ra.size(), 1);
        if (ra.size() > 0) check("R12 restored arch", ra[0], 8);
        clear_logs();
        commit(200);
        check("R12 one left", fl.size(), 1);
        if (fl.size() > 0) check("R12 survivor prev", fl[0], 34);
    endtask

    task automatic t_overlap();
        clear_logs();
        push(80, 1, 1, 41, 42);
        push(81, 1, 2, 43, 44);
        push(82, 1, 3, 45, 46);
        cm_valid = 1; cm_seq = 80;
        @(negedge clk);
        cm_valid = 0;
        sq_valid = 1; sq_seq = 80;
        @(negedge clk);
        sq_valid = 0;
        wait_idle();
        check("R11 pulse count", fl.size(), 3);
        if (fl.size() > 2) begin
            check("R11 commit first", fl[0], 42);
            check("R11 then youngest", fl[1], 45);
            check("R11 then next", fl[2], 43);
        end
        check("R11 restores", ra.size(), 2);
        check("R11 empty", int'(empty), 1);
        clear_logs();
        for (int i = 0; i < 4; i++) push(90 + i, 1, i + 1, 60 + i, 70 + i);
        sq_valid = 1; sq_seq = 92;
        @(negedge clk);
        sq_seq = 90;
        @(negedge clk);
        sq_valid = 0;
        wait_idle();
        check("R11 lowered limit", ra.size(), 3);
        clear_logs();
        commit(90);
        check("R11 survivor", fl.size(), 1);
        check("R11 drained", int'(empty), 1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_commit_basic();
        t_squash_basic();
        t_squash_empty();
        t_commit_ignored();
        t_full();
        t_busy_blocks();
        t_priority();
        t_overlap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule